// File: doc/BRIEF.md
# Serial Command Frame Slave Port

This block is the serial slave side of a converter-style device. The host opens a frame by pulling an active-low select line low. The block then loads a parallel result word into an output shifter, clears a command holding register and pulls its ready line low. While select is low, each rising serial clock edge captures one host bit into the low end of an input shifter. Each falling serial clock edge advances the output shifter, so that result bits leave most significant first.

When select returns high, the block stops driving the serial output and sorts the frame by the number of rising clock edges it saw. With 32 or more clocks, the last 32 captured bits become the command word. With fewer, the write is discarded and an all-zero no-operation word is issued in its place. In both cases a one-cycle valid strobe accompanies the word. The ready line then stays low for a fixed conversion interval, counted in system clocks. A select fall during that interval is ignored and reported as a protocol error.

All serial inputs are resynchronised into the system clock domain. The serial clock must therefore run well below the system clock.

Top module: `spiCmdSlave`

## Requirements
- R1: While reset is held and in the first cycle after it, ready is 1 and sdoEn, cmdValid and protoErr are 0.
- R2: A few system cycles after csN falls while ready is 1, ready reads 0, sdoEn reads 1 and sdo shows bit 31 of the outWord value present at that time.
- R3: Each falling sclk edge inside a frame advances the output by one bit, most significant first. After k falls sdo shows bit 31-k of the loaded word, and it shows 0 once k reaches 32.
- R4: Each rising sclk edge inside a frame shifts sdi into bit 0 of the input register, and earlier bits move toward bit 31.
- R5: A frame with exactly 32 rising sclk edges yields cmdValid high for exactly one cycle after csN rises, with cmdWord equal to the 32 captured bits, the first captured bit in bit 31.
- R6: A frame with fewer than 32 rising sclk edges (including none) yields the cmdValid strobe with cmdWord equal to 0, the no-operation code.
- R7: A frame with more than 32 rising sclk edges, of any length, yields cmdWord equal to the last 32 bits captured before csN rose. The edge count saturates, so lengths such as 80 are never taken as short.
- R8: After csN rises, sdoEn is 0 no later than the cycle in which cmdValid is high.
- R9: Ready is 0 in the cmdValid cycle and stays 0 for CONV_CYCLES cycles in all, counting that cycle; it then reads 1.
- R10: A csN fall while ready is 0 after a frame raises protoErr for one cycle. It starts no frame: sdoEn stays 0 and the conversion length is unchanged.
- R11: cmdWord reads 0 from the start of a frame until the frame's cmdValid cycle, and it changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select / conversion start |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| outWord | input | WORD_W | Result word loaded at frame start |
| sdo | output | 1 | Serial data to host, valid while sdoEn is 1 |
| sdoEn | output | 1 | Output drive enable; 0 means high impedance |
| ready | output | 1 | 1 when idle; 0 during a frame and the conversion interval |
| cmdWord | output | WORD_W | Command word (0 = no-operation) |
| cmdValid | output | 1 | One-cycle strobe marking a new cmdWord |
| protoErr | output | 1 | One-cycle pulse on a select fall during conversion |

## Verification
The edge counter shows up only at frame end. A count that wraps or stops early turns a long frame into a zero word, and a count that runs one too far accepts a 31-clock frame. Sweeping every frame length from 0 to 40 plus several long lengths exposes both within one commit. A wrong output shifter shows on sdo before the very next rising sclk edge, because every bit position is compared. A wrong conversion timer shows as a ready-low interval that differs from CONV_CYCLES, measured from the valid strobe.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;
  // Strobes from the frame controller to the shift datapath
  typedef struct packed {
    logic load;     // frame start: load output word, clear command
    logic capture;  // rising serial clock: shift input in
    logic launch;   // falling serial clock: advance output
    logic commit;   // frame end: publish command
    logic accept;   // frame end with enough clocks
  } frameStrobes_t;
endpackage

// File: rtl/spiFrameCtrl.sv
module spiFrameCtrl
  import spiCmdPkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sclk,
  input  logic          sdi,
  output frameStrobes_t strb,
  output logic          sdiS,
  output logic          frameActive,
  output logic          ready,
  output logic          protoErr
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int TMR_W   = $clog2(CONV_CYCLES) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_CONV} state_t;

  logic [SYNC_STAGES-1:0] csSync, sclkSync, sdiSync;
  logic csS, sclkS, csPrev, sclkPrev;
  logic csFall, csRise, sclkRise, sclkFall;
  state_t state;
  logic [CNT_W-1:0] clkCnt;
  logic [TMR_W-1:0] convTmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= '1;
      sclkSync <= '0;
      sdiSync  <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      sdiSync  <= {sdiSync[SYNC_STAGES-2:0], sdi};
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csS   = csSync[SYNC_STAGES-1];
  assign sclkS = sclkSync[SYNC_STAGES-1];
  assign sdiS  = sdiSync[SYNC_STAGES-1];

  always_comb begin
    csFall   = csPrev & ~csS;
    csRise   = ~csPrev & csS;
    sclkRise = ~sclkPrev & sclkS;
    sclkFall = sclkPrev & ~sclkS;
    strb.load    = (state == ST_IDLE) && csFall;
    strb.capture = (state == ST_FRAME) && sclkRise && !csS;
    strb.launch  = (state == ST_FRAME) && sclkFall && !csS;
    strb.commit  = (state == ST_FRAME) && csRise;
    strb.accept  = strb.commit && (clkCnt >= CNT_W'(WORD_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      clkCnt   <= '0;
      convTmr  <= '0;
      protoErr <= 1'b0;
    end else begin
      protoErr <= (state == ST_CONV) && csFall;
      case (state)
        ST_IDLE: if (strb.load) begin
          state  <= ST_FRAME;
          clkCnt <= '0;
        end
        ST_FRAME: begin
          if (strb.capture && clkCnt != CNT_W'(CNT_MAX)) clkCnt <= clkCnt + 1'b1;
          if (strb.commit) begin
            state   <= ST_CONV;
            convTmr <= '0;
          end
        end
        default: begin
          if (convTmr == TMR_W'(CONV_CYCLES - 1)) state <= ST_IDLE;
          else convTmr <= convTmr + 1'b1;
        end
      endcase
    end
  end

  assign ready       = (state == ST_IDLE);
  assign frameActive = (state == ST_FRAME);
endmodule

// File: rtl/spiFrameDp.sv
module spiFrameDp
  import spiCmdPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobes_t     strb,
  input  logic              sdiS,
  input  logic [WORD_W-1:0] outWord,
  output logic              sdo,
  output logic [WORD_W-1:0] cmdWord,
  output logic              cmdValid
);
  logic [WORD_W-1:0] outSr, inSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSr    <= '0;
      inSr     <= '0;
      cmdWord  <= '0;
      cmdValid <= 1'b0;
    end else begin
      cmdValid <= strb.commit;
      if (strb.load) begin
        outSr   <= outWord;
        cmdWord <= '0;
      end else if (strb.launch) begin
        outSr <= {outSr[WORD_W-2:0], 1'b0};
      end
      if (strb.capture) inSr <= {inSr[WORD_W-2:0], sdiS};
      if (strb.commit) cmdWord <= strb.accept ? inSr : '0;
    end
  end

  assign sdo = outSr[WORD_W-1];
endmodule

// File: rtl/spiCmdSlave.sv
module spiCmdSlave
  import spiCmdPkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [WORD_W-1:0] outWord,
  output logic              sdo,
  output logic              sdoEn,
  output logic              ready,
  output logic [WORD_W-1:0] cmdWord,
  output logic              cmdValid,
  output logic              protoErr
);
  frameStrobes_t strb;
  logic sdiS;

  spiFrameCtrl #(.WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .strb(strb), .sdiS(sdiS), .frameActive(sdoEn), .ready(ready), .protoErr(protoErr)
  );

  spiFrameDp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiS(sdiS), .outWord(outWord),
    .sdo(sdo), .cmdWord(cmdWord), .cmdValid(cmdValid)
  );
endmodule

// File: rtl/spiCmdSlaveChecker.sv
module spiCmdSlaveChecker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdoEn,
  input logic              ready,
  input logic              cmdValid,
  input logic              protoErr,
  input logic [WORD_W-1:0] cmdWord
);
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  p_drive_not_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !ready);
  p_valid_after_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (!sdoEn && !ready));
  p_err_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> !protoErr);
  p_err_no_drive_r10: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> (!sdoEn && !ready));
  p_hold_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> (cmdWord == '0));
  p_cmd_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !$rose(sdoEn)) |-> $stable(cmdWord));
endmodule

bind spiCmdSlave spiCmdSlaveChecker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .sdoEn(sdoEn), .ready(ready),
  .cmdValid(cmdValid), .protoErr(protoErr), .cmdWord(cmdWord)
);

// File: tb/spiCmdSlave_bench.sv
module spiCmdSlave_bench;
  localparam int W    = 32;
  localparam int CONV = 40;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [W-1:0] outWord = '0;
  logic sdo, sdoEn, ready, cmdValid, protoErr;
  logic [W-1:0] cmdWord;
  int checks = 0, errors = 0, errPulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spiCmdSlave #(.WORD_W(W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u_spiCmdSlave (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .outWord(outWord),
    .sdo(sdo), .sdoEn(sdoEn), .ready(ready), .cmdWord(cmdWord),
    .cmdValid(cmdValid), .protoErr(protoErr)
  );

  always @(negedge clk) if (rstN && protoErr) errPulses++;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One frame of n clocks; if errAfter, select drops again during conversion
  task automatic frame(input int n, input int seed, input bit errAfter);
    logic [W-1:0] ow, expCmd;
    int vcnt, lowCnt, pulses0;
    ow = {16'hA5C3, 16'(seed)} ^ (32'h0101_0101 * 32'(n));
    expCmd = '0;
    outWord = ow;
    @(negedge clk); csN = 1'b0;
    waitN(8);
    chk(ready == 1'b0, "R2 ready", W'(ready), '0);
    chk(sdoEn == 1'b1, "R2 sdoEn", W'(sdoEn), 1);
    chk(cmdWord == '0, "R11 cleared", cmdWord, '0);
    for (int k = 0; k < n; k++) begin
      logic b, e;
      e = (k < W) ? ow[W-1-k] : 1'b0;
      chk(sdo == e, (k == 0) ? "R2 first bit" : "R3 sdo bit", W'(sdo), W'(e));
      b = (((k * 13 + seed) % 7) > 2);
      expCmd = {expCmd[W-2:0], b};
      sdi = b; sclk = 1'b1;
      waitN(HALF);
      sclk = 1'b0;
      waitN(HALF);
    end
    chk(cmdWord == '0, "R11 held", cmdWord, '0);
    csN = 1'b1;
    vcnt = 0;
    while (!cmdValid && vcnt < 30) begin @(negedge clk); vcnt++; end
    if (n >= W) chk(cmdValid && cmdWord == expCmd, (n == W) ? "R5 exact" : "R7 long", cmdWord, expCmd);
    else        chk(cmdValid && cmdWord == '0, "R6 short nop", cmdWord, '0);
    chk(sdoEn == 1'b0, "R8 released", W'(sdoEn), '0);
    pulses0 = errPulses;
    lowCnt = 0;
    while (!ready && lowCnt < 1000) begin
      lowCnt++;
      if (errAfter && lowCnt == 5) csN = 1'b0;
      @(negedge clk);
      chk(!cmdValid, "R5 single strobe", W'(cmdValid), '0);
    end
    chk(lowCnt == CONV, "R9 conversion length", W'(lowCnt), W'(CONV));
    if (errAfter) begin
      chk(errPulses == pulses0 + 1, "R10 error pulse", W'(errPulses - pulses0), 1);
      waitN(10);
      chk(!sdoEn && ready, "R10 no frame", W'({sdoEn, ready}), 1);
      chk(cmdWord == (n >= W ? expCmd : '0), "R11 unchanged", cmdWord, (n >= W ? expCmd : '0));
      csN = 1'b1;
      waitN(10);
    end else begin
      chk(errPulses == pulses0, "R10 no spurious", W'(errPulses - pulses0), '0);
    end
    waitN(4);
  endtask

  initial begin
    waitN(3);
    chk(ready && !sdoEn && !cmdValid && !protoErr, "R1 in reset",
        W'({ready, sdoEn, cmdValid, protoErr}), 32'h8);
    rstN = 1'b1;
    @(negedge clk);
    chk(ready && !sdoEn && !cmdValid && !protoErr, "R1 after reset",
        W'({ready, sdoEn, cmdValid, protoErr}), 32'h8);
    // R4 is covered by cmdWord comparisons of captured bit order
    for (int n = 0; n <= 40; n++) frame(n, n * 3 + 1, 1'b0);
    frame(63, 5, 1'b0);
    frame(64, 9, 1'b0);
    frame(65, 2, 1'b0);
    frame(80, 4, 1'b0);   // R7: would wrap a narrow counter into the short range
    frame(100, 6, 1'b0);
    frame(32, 11, 1'b1);  // R10
    frame(7, 12, 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule